// File: doc/BRIEF.md
# Logarithmic LED Dimming Sequencer

This block owns the 5-bit brightness code that feeds an LED current DAC. The DAC maps the code onto a fixed logarithmic curve. Code 0 gives zero current, code 31 gives full scale, and each code above 1 is about 2 dB brighter than the one below it. A host-side decoder hands the block one-cycle write strobes, each with an 8-bit data byte. The block also takes a millisecond tick and a shutdown input.

There are four write strobes:
- An immediate-set write jumps the code straight to a new value.
- An upward-target write or a downward-target write records an end code and a direction. It moves nothing.
- A timing write records the time per step and launches a ramp. The ramp runs from the present code toward the recorded end code, one code per step period.

During a ramp `busy` is high. When the ramp arrives, `done` pulses for one cycle.

The control is a two-state machine:
- **ST_IDLE**: the code is held.
- **ST_RAMP**: the code moves one step per period.

It has these transitions:
- *launch*: ST_IDLE to ST_RAMP, on a timing write whose target lies ahead in the recorded direction.
- *arrive*: ST_RAMP to ST_IDLE, on the step that reaches the target.
- *null start*: ST_RAMP to ST_IDLE, on a timing write whose target is not ahead.
- *abort*: to ST_IDLE from either state, on shutdown or on an immediate set.
- *restart*: ST_RAMP to ST_RAMP, on a timing write whose target lies ahead.

A timing write in ST_IDLE whose target is not ahead leaves the machine in ST_IDLE and pulses `done`.

Top module: `led_dim_seq`

## Requirements
- R1: After reset `step_idx` is 0, `busy` is 0 and `done` is 0.
- R2: When `wr_set` is high (and `shutdown` is low), `step_idx` takes `wr_data[4:0]` on that clock edge. Any ramp in progress is cancelled, so `busy` is 0 the next cycle, and `done` does not pulse.
- R3: `wr_up` stores `wr_data[4:0]` as the target with direction up. `wr_down` stores it with direction down. If both strobes are high in one cycle, `wr_up` wins. Neither strobe changes `step_idx`, `busy` or `done`.
- R4: A timing write (`wr_time`) whose stored target lies ahead in the stored direction raises `busy` on the next cycle. The write uses the target and direction that were stored before that cycle's edge. `step_idx` then moves by exactly 1 toward the target once every step period.
- R5: The step period is `P*UNIT_TICKS` ticks of `ms_tick`, where P is `wr_data[4:0]` of the timing write. The bits of P weigh 10, 20, 40, 80 and 160 ms (bit 0 to bit 4) when UNIT_TICKS is 10 at one tick per ms. P = 0 means one tick per step.
- R6: On the step that makes `step_idx` equal to the target, `busy` falls and `done` is high for exactly that one cycle. With a tick every cycle, a ramp of N steps holds `busy` for N*period cycles.
- R7: A timing write whose target is not ahead of `step_idx` pulses `done` on the next cycle and leaves `step_idx` unchanged with `busy` 0. This covers an up target at or below the code and a down target at or above it.
- R8: A timing write during a ramp restarts it from the present `step_idx`. It clears the step timer and uses the most recently stored target and direction.
- R9: Bits 7 to 5 of `wr_data` have no effect on any write.
- R10: `shutdown` has the highest priority. On the next cycle `step_idx` is 0 and `busy` is 0, even when a set or timing write comes in the same cycle.
- R11: `step_idx` never leaves 0 to 31 and never wraps. Outside set and shutdown it changes by at most 1 per cycle.
- R12: In one cycle an immediate set beats a timing write, and a timing write beats a step that falls due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shutdown | input | 1 | Forces the code to 0 and stops any ramp |
| ms_tick | input | 1 | One-cycle time base pulse (1 ms) |
| wr_set | input | 1 | Immediate-set write strobe |
| wr_up | input | 1 | Upward-target write strobe |
| wr_down | input | 1 | Downward-target write strobe |
| wr_time | input | 1 | Step-time write strobe that also starts a ramp |
| wr_data | input | 8 | Data byte of the write; bits 4:0 used |
| step_idx | output | 5 | Present brightness code to the current DAC |
| busy | output | 1 | High while a ramp is in progress |
| done | output | 1 | One-cycle pulse when a ramp completes or is a no-op |

## Verification
Several things can coincide in one cycle:
- a falling-due step with a restarting timing write;
- an immediate set with a timing write;
- shutdown with an immediate set.

The bench provokes the first by keeping `ms_tick` high every cycle with a one-tick period, so every cycle has a step due, and then issuing a new timing write mid-ramp. It provokes the other two by raising both strobes in one cycle. A behavioural model that applies the priority order shutdown, set, timing write, step is compared with the ports on every clock. Targeted checks also confirm the winning outcome: the set value with `busy` low, or a code of 0.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;
    parameter int unsigned IDX_W   = 5;
    parameter int unsigned FIELD_W = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RAMP = 1'b1
    } dim_state_e;
endpackage

// File: rtl/led_dim_period.sv
// Converts the binary-weighted step-time field into a tick count.
module led_dim_period #(
    parameter int unsigned UNIT_TICKS = 10,
    parameter int unsigned FIELD_W    = 5,
    parameter int unsigned CNT_W      = 9
) (
    input  logic [FIELD_W-1:0] field,
    output logic [CNT_W-1:0]   limit
);
    logic [CNT_W-1:0] partial [FIELD_W+1];

    assign partial[0] = '0;

    for (genvar g = 0; g < FIELD_W; g++) begin : g_weight
        localparam logic [CNT_W-1:0] WEIGHT = CNT_W'(UNIT_TICKS << g);
        assign partial[g+1] = partial[g] + (field[g] ? WEIGHT : '0);
    end

    assign limit = (field == '0) ? CNT_W'(1) : partial[FIELD_W];
endmodule

// File: rtl/led_dim_ticker.sv
// Counts time-base ticks and flags when a step period has elapsed.
module led_dim_ticker #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             step_due
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end   = (cnt_q == limit - CNT_W'(1));
    assign step_due = !clear && tick && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/led_dim_fsm.sv
// Ramp control: state register, target latches and the brightness code.
module led_dim_fsm
    import led_dim_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shutdown,
    input  logic               wr_set,
    input  logic               wr_up,
    input  logic               wr_down,
    input  logic               wr_time,
    input  logic [FIELD_W-1:0] data,
    input  logic               step_due,
    output logic [IDX_W-1:0]   idx,
    output logic               busy,
    output logic               done,
    output logic [FIELD_W-1:0] period,
    output logic               cnt_clear
);
    dim_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q, tgt_q, act_tgt_q, idx_step;
    logic             dir_q, act_dir_q, done_q;
    logic [FIELD_W-1:0] per_q;
    logic             no_move, at_rail, arrive;

    // A start is a no-op when the stored target is not ahead of the code.
    assign no_move  = dir_q ? (tgt_q <= idx_q) : (tgt_q >= idx_q);
    assign at_rail  = act_dir_q ? (idx_q == '1) : (idx_q == '0);
    assign idx_step = at_rail ? idx_q
                    : (act_dir_q ? idx_q + IDX_W'(1) : idx_q - IDX_W'(1));
    assign arrive   = step_due && ((idx_step == act_tgt_q) || at_rail);

    always_comb begin
        state_d = state_q;
        if (shutdown || wr_set) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (wr_time && !no_move) state_d = ST_RAMP;
                ST_RAMP: begin
                    if (wr_time)     state_d = no_move ? ST_IDLE : ST_RAMP;
                    else if (arrive) state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q     <= '0;
            tgt_q     <= '0;
            dir_q     <= 1'b0;
            act_tgt_q <= '0;
            act_dir_q <= 1'b0;
            per_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (wr_up) begin
                tgt_q <= data;
                dir_q <= 1'b1;
            end else if (wr_down) begin
                tgt_q <= data;
                dir_q <= 1'b0;
            end
            if (shutdown) begin
                idx_q <= '0;
            end else if (wr_set) begin
                idx_q <= data;
            end else if (wr_time) begin
                per_q <= data;
                if (no_move) begin
                    done_q <= 1'b1;
                end else begin
                    act_tgt_q <= tgt_q;
                    act_dir_q <= dir_q;
                end
            end else if (state_q == ST_RAMP && step_due) begin
                idx_q <= idx_step;
                if (arrive) done_q <= 1'b1;
            end
        end
    end

    assign idx       = idx_q;
    assign busy      = (state_q == ST_RAMP);
    assign done      = done_q;
    assign period    = per_q;
    assign cnt_clear = (state_q != ST_RAMP) || wr_time || wr_set || shutdown;
endmodule

// File: rtl/led_dim_seq.sv
module led_dim_seq
    import led_dim_pkg::*;
#(
    parameter int unsigned UNIT_TICKS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shutdown,
    input  logic       ms_tick,
    input  logic       wr_set,
    input  logic       wr_up,
    input  logic       wr_down,
    input  logic       wr_time,
    input  logic [7:0] wr_data,
    output logic [4:0] step_idx,
    output logic       busy,
    output logic       done
);
    localparam int unsigned MAX_TICKS = UNIT_TICKS * ((1 << FIELD_W) - 1);
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

    logic [FIELD_W-1:0] field_q;
    logic [CNT_W-1:0]   limit;
    logic               cnt_clear, step_due;
    logic               unused_rsv;

    assign unused_rsv = ^wr_data[7:FIELD_W];

    led_dim_period #(
        .UNIT_TICKS(UNIT_TICKS),
        .FIELD_W   (FIELD_W),
        .CNT_W     (CNT_W)
    ) u_period (
        .field(field_q),
        .limit(limit)
    );

    led_dim_ticker #(.CNT_W(CNT_W)) u_ticker (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .tick    (ms_tick),
        .limit   (limit),
        .step_due(step_due)
    );

    led_dim_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .shutdown (shutdown),
        .wr_set   (wr_set),
        .wr_up    (wr_up),
        .wr_down  (wr_down),
        .wr_time  (wr_time),
        .data     (wr_data[FIELD_W-1:0]),
        .step_due (step_due),
        .idx      (step_idx),
        .busy     (busy),
        .done     (done),
        .period   (field_q),
        .cnt_clear(cnt_clear)
    );
endmodule

// File: rtl/led_dim_seq_chk.sv
module led_dim_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       shutdown,
    input logic       wr_set,
    input logic       wr_up,
    input logic       wr_down,
    input logic       wr_time,
    input logic [7:0] wr_data,
    input logic [4:0] step_idx,
    input logic       busy,
    input logic       done
);
    p_set_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !shutdown) |=> (step_idx == $past(wr_data[4:0])) && !busy && !done);

    p_target_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_up || wr_down) && !busy && !wr_set && !wr_time && !shutdown)
        |=> $stable(step_idx) && !busy);

    p_start_reacts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_time && !wr_set && !shutdown) |=> (busy != done));

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_shutdown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (step_idx == 5'd0) && !busy);

    p_one_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !shutdown)
        |=> ({1'b0, step_idx} == {1'b0, $past(step_idx)})
         || ({1'b0, step_idx} == {1'b0, $past(step_idx)} + 6'd1)
         || ({1'b0, step_idx} + 6'd1 == {1'b0, $past(step_idx)}));
endmodule

bind led_dim_seq led_dim_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .shutdown(shutdown),
    .wr_set  (wr_set),
    .wr_up   (wr_up),
    .wr_down (wr_down),
    .wr_time (wr_time),
    .wr_data (wr_data),
    .step_idx(step_idx),
    .busy    (busy),
    .done    (done)
);

// File: tb/led_dim_seq_bench.sv
`timescale 1ns/1ps
module led_dim_seq_bench;
    localparam int UNIT = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shutdown = 1'b0, ms_tick = 1'b0;
    logic       wr_set = 1'b0, wr_up = 1'b0, wr_down = 1'b0, wr_time = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [4:0] step_idx;
    logic       busy, done;

    int checks = 0, failures = 0, cycles = 0, tick_every = 1, tick_ph = 0;
    bit finished = 0;

    // behavioural reference model state
    int  m_idx = 0, m_tgt = 0, m_atgt = 0, m_per = 0, m_cnt = 0;
    bit  m_dir = 0, m_adir = 0, m_busy = 0, m_done = 0;

    always #2.5 clk = ~clk;

    led_dim_seq #(.UNIT_TICKS(UNIT)) u_led_dim_seq (
        .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .ms_tick(ms_tick),
        .wr_set(wr_set), .wr_up(wr_up), .wr_down(wr_down), .wr_time(wr_time),
        .wr_data(wr_data), .step_idx(step_idx), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_tgt = 0; m_atgt = 0; m_per = 0; m_cnt = 0;
            m_dir = 0; m_adir = 0; m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (shutdown) begin
                m_idx = 0; m_busy = 0;
            end else if (wr_set) begin
                m_idx = wr_data % 32; m_busy = 0;
            end else if (wr_time) begin
                m_per = wr_data % 32; m_cnt = 0;
                if ((m_dir && m_tgt <= m_idx) || (!m_dir && m_tgt >= m_idx)) begin
                    m_done = 1; m_busy = 0;
                end else begin
                    m_busy = 1; m_atgt = m_tgt; m_adir = m_dir;
                end
            end else if (m_busy && ms_tick) begin
                m_cnt++;
                if (m_cnt >= ((m_per == 0) ? 1 : m_per * UNIT)) begin
                    m_cnt = 0;
                    m_idx = m_adir ? m_idx + 1 : m_idx - 1;
                    if (m_idx == m_atgt) begin m_busy = 0; m_done = 1; end
                end
            end
            if (wr_up) begin m_tgt = wr_data % 32; m_dir = 1; end
            else if (wr_down) begin m_tgt = wr_data % 32; m_dir = 0; end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(step_idx == m_idx, "R11 model step_idx", step_idx, m_idx);
            chk(busy == m_busy, "R4 model busy", busy, m_busy);
            chk(done == m_done, "R6 model done", done, m_done);
        end
    end

    always @(negedge clk) begin
        #1;
        tick_ph++;
        ms_tick = ((tick_ph % tick_every) == 0);
    end

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    // kind: 0 set, 1 up, 2 down, 3 time, 4 shutdown
    task automatic strobe(input int kind, input bit on);
        case (kind)
            0: wr_set = on;
            1: wr_up = on;
            2: wr_down = on;
            3: wr_time = on;
            default: shutdown = on;
        endcase
    endtask

    task automatic put2(input int k1, input int k2, input logic [7:0] d);
        @(negedge clk); #1;
        wr_data = d; strobe(k1, 1); strobe(k2, 1);
        @(negedge clk); #1;
        strobe(k1, 0); strobe(k2, 0);
    endtask

    task automatic put(input int kind, input logic [7:0] d);
        put2(kind, kind, d);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int n, s;

    initial begin
        idle(3);
        chk(step_idx == 0 && busy == 0 && done == 0, "R1 reset outputs", {step_idx, busy, done}, 0);
        rst_n = 1'b1;
        idle(2);

        put(0, 8'hE5);
        chk(step_idx == 5, "R2 R9 set with reserved bits", step_idx, 5);
        put(1, 8'h2A);
        chk(step_idx == 5 && !busy, "R3 target write moves nothing", step_idx, 5);
        put(3, 8'hE0);
        chk(busy == 1, "R4 ramp starts", busy, 1);
        count_busy(n);
        chk(n == 5, "R5 R6 period 0 one tick per step", n, 5);
        chk(done == 1 && step_idx == 10, "R6 arrive done and idx", step_idx, 10);
        idle(1);
        chk(done == 0, "R6 done one cycle", done, 0);

        put(2, 8'h07);
        put(3, 8'h02);
        count_busy(n);
        chk(n == 3 * 2 * UNIT, "R5 period 2 gives 20 units per step", n, 60);
        chk(step_idx == 7, "R4 downward end", step_idx, 7);

        put(1, 8'h03);
        put(3, 8'h00);
        chk(done == 1 && !busy && step_idx == 7, "R7 up target below", step_idx, 7);
        put(2, 8'h09);
        put(3, 8'h00);
        chk(done == 1 && !busy && step_idx == 7, "R7 down target above", step_idx, 7);
        put(1, 8'h07);
        put(3, 8'h00);
        chk(done == 1 && !busy, "R7 equal target", done, 1);

        put(1, 8'h1F);
        put(3, 8'h01);
        idle(25);
        put(2, 8'h02);
        chk(busy == 1, "R3 target write during ramp keeps ramp", busy, 1);
        put(3, 8'h00);
        s = step_idx;
        count_busy(n);
        chk(n == s - 2 && step_idx == 2, "R8 restart from present index", n, s - 2);

        put(0, 8'd20);
        put(1, 8'd25);
        put2(0, 3, 8'd10);
        chk(step_idx == 10 && !busy, "R12 set beats timing write", step_idx, 10);

        put(3, 8'h00);
        idle(2);
        put2(4, 0, 8'd17);
        chk(step_idx == 0 && !busy, "R10 shutdown beats set", step_idx, 0);

        put(0, 8'd12);
        put(1, 8'd20);
        put(3, 8'h00);
        idle(3);
        put(3, 8'h00);
        count_busy(n);
        chk(step_idx == 20, "R12 timing write beats due step", step_idx, 20);

        put(0, 8'd28);
        put(1, 8'hFF);
        put(3, 8'h00);
        count_busy(n);
        idle(5);
        chk(step_idx == 31 && !busy, "R11 top code holds", step_idx, 31);
        put(3, 8'h00);
        chk(done == 1 && step_idx == 31, "R11 R7 start at top is no-op", step_idx, 31);

        tick_every = 3;
        put(2, 8'd25);
        put(3, 8'h01);
        count_busy(n);
        chk(step_idx == 25, "R5 sparse ticks reach target", step_idx, 25);
        tick_every = 1;

        put(0, 8'd4);
        put(2, 8'd0);
        put(3, 8'h00);
        count_busy(n);
        idle(3);
        chk(step_idx == 0 && !busy, "R11 bottom code holds", step_idx, 0);

        idle(2);
        finish_run();
    end
endmodule